// File: doc/BRIEF.md
# Multi-Mode Compare Timer

An up-counting timer that advances on a prescaler clock-enable pulse. It compares the count against a programmable compare value. The timer has three modes. In one-shot mode it stops itself after the first match. Periodic mode repeats the match every period. Toggle mode repeats like periodic mode and also inverts an output pin on every match.

Software controls the block through a small register file. Each port access is one write strobe with an address. Reads are combinational from the same address. A sticky interrupt flag records matches and is cleared by writing 1 to it. The interrupt request is a level signal that is high while the flag is set and interrupts are enabled.

Top module: `mode_timer`

## Requirements
- R1: After reset, the counter, enable, interrupt-enable, mode, compare value, flag, interrupt request and toggle output are all 0.
- R2: Register addresses and layout, all read combinationally on `reg_rdata`:
  - Address 0 is control: bit 0 enable, bit 1 interrupt enable, bits 3:2 mode.
  - Address 1 is the compare value.
  - Address 2 is status, with the flag in bit 0.
  - Address 3 is the counter and is read-only.
  - Unused bits read 0.
- R3: The counter increases by one on each clock where `tick` is 1 and enable is 1. In every other clock it holds its value.
- R4: A match occurs on a tick when the counter is at or above the effective compare value. The effective compare value is the compare register, or 1 if the register is 0. On a match the counter returns to 0, so the period is compare+1 ticks.
- R5: In mode 00 (one-shot), a match clears the enable bit. The counter then stays at 0 until software enables the timer again.
- R6: In modes 01 (periodic) and 11 (treated as periodic), the enable bit stays 1 after a match and counting continues.
- R7: In mode 10 (toggle), `tout` inverts on every match. `tout` resets to 0 and otherwise holds its level, including while the timer is disabled.
- R8: A match sets the flag only when interrupt enable is 1. `irq` is 1 exactly while the flag and interrupt enable are both 1.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. If a match sets the flag in the same cycle as a clear, the flag ends up set.
- R10: A control write with enable 0 stops the timer and sets the counter to 0. A control write that enables a stopped timer starts it from 0. A control write in the same cycle as a one-shot match decides the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler clock enable that advances the counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for `reg_addr` |
| count_o | output | WIDTH | Current counter value |
| irq | output | 1 | Level interrupt request |
| tout | output | 1 | Toggle output pin |

## Verification
The bench builds the timer with WIDTH = 8. With that width, the counter can run up to its wrap-around within a few hundred cycles. Random compare values are drawn mostly from 0 to 15, so matches, the compare-of-zero rule and compare values lowered below the running count all happen often. Directed sequences cover the same-cycle races: a flag clear against a hardware set, and a control write against a one-shot self-stop.

// File: rtl/mode_timer.sv
module mode_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  output logic [WIDTH-1:0] count_o,
  output logic             irq,
  output logic             tout
);

  localparam logic [1:0]       A_CTRL = 2'd0;
  localparam logic [1:0]       A_CMP  = 2'd1;
  localparam logic [1:0]       A_STS  = 2'd2;
  localparam logic [1:0]       M_ONE  = 2'b00;
  localparam logic [1:0]       M_TOG  = 2'b10;
  localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);

  logic             en_q, ie_q, flag_q, tout_q;
  logic [1:0]       mode_q;
  logic [WIDTH-1:0] cmp_q, cnt_q;

  wire ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  wire cmp_wr  = reg_wr && (reg_addr == A_CMP);
  wire sts_wr  = reg_wr && (reg_addr == A_STS);

  wire [WIDTH-1:0] cmp_eff = (cmp_q == '0) ? ONE : cmp_q;
  wire             step    = en_q && tick;
  wire             hit     = step && (cnt_q >= cmp_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= M_ONE;
      cmp_q  <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      if (hit)
        cnt_q <= '0;
      else if (step)
        cnt_q <= cnt_q + ONE;

      if (hit && mode_q == M_ONE)
        en_q <= 1'b0;

      if (ctrl_wr) begin
        en_q   <= reg_wdata[0];
        ie_q   <= reg_wdata[1];
        mode_q <= reg_wdata[3:2];
        if (!reg_wdata[0] || !en_q)
          cnt_q <= '0;
      end

      if (cmp_wr)
        cmp_q <= reg_wdata;

      if (hit && mode_q == M_TOG)
        tout_q <= ~tout_q;

      if (sts_wr && reg_wdata[0])
        flag_q <= 1'b0;
      if (hit && ie_q)
        flag_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[3:0] = {mode_q, ie_q, en_q};
      A_CMP:   reg_rdata = cmp_q;
      A_STS:   reg_rdata[0] = flag_q;
      default: reg_rdata = cnt_q;
    endcase
  end

  assign count_o = cnt_q;
  assign irq     = flag_q & ie_q;
  assign tout    = tout_q;

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt_q == '0);

  p_oneshot_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == M_ONE && !ctrl_wr) |=> !en_q);

  p_periodic_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q[0] && !ctrl_wr) |=> en_q);

  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == M_TOG) |=> tout_q != $past(tout_q));

  p_tout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && mode_q == M_TOG) |=> $stable(tout_q));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ie_q) |=> flag_q);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> cnt_q == '0);

endmodule

// File: tb/mode_timer_tb_top.sv
module mode_timer_tb_top;
  localparam int W   = 8;
  localparam int CLK = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata, count_o;
  logic         irq, tout;

  int compared = 0;
  int mismatched = 0;

  logic         m_en = 0, m_ie = 0, m_flag = 0, m_tout = 0;
  logic [1:0]   m_mode = 0;
  logic [W-1:0] m_cmp = 0, m_cnt = 0;

  always #(CLK/2) clk = ~clk;

  mode_timer #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o), .irq(irq), .tout(tout)
  );

  function automatic logic [W-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return W'({m_mode, m_ie, m_en});
      2'd1:    return m_cmp;
      2'd2:    return W'(m_flag);
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic wr, input logic [1:0] a, input logic [W-1:0] d, input logic tk);
    logic [W-1:0] eff = (m_cmp == '0) ? W'(1) : m_cmp;
    logic hit = m_en && tk && (m_cnt >= eff);
    logic         n_en = m_en, n_ie = m_ie, n_flag = m_flag, n_tout = m_tout;
    logic [1:0]   n_mode = m_mode;
    logic [W-1:0] n_cmp = m_cmp, n_cnt = m_cnt;
    if (hit) n_cnt = '0;
    else if (m_en && tk) n_cnt = m_cnt + 1'b1;
    if (hit && m_mode == 2'b00) n_en = 0;
    if (hit && m_mode == 2'b10) n_tout = ~m_tout;
    if (wr && a == 2'd2 && d[0]) n_flag = 0;
    if (hit && m_ie) n_flag = 1;
    if (wr && a == 2'd0) begin
      n_en = d[0]; n_ie = d[1]; n_mode = d[3:2];
      if (!d[0] || !m_en) n_cnt = '0;
    end
    if (wr && a == 2'd1) n_cmp = d;
    m_en = n_en; m_ie = n_ie; m_flag = n_flag; m_tout = n_tout;
    m_mode = n_mode; m_cmp = n_cmp; m_cnt = n_cnt;
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [W-1:0] d, input logic tk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick = tk;
    @(posedge clk);
    model_edge(wr, a, d, tk);
    #(CLK/2);
    reg_wr = 0; tick = 0;
    #1;
    chk("R3 count", count_o, m_cnt);
    chk("R8 irq", W'(irq), W'(m_flag & m_ie));
    chk("R7 tout", W'(tout), W'(m_tout));
    chk("R2 rdata", reg_rdata, exp_read(a));
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
    step(1, a, d, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd3, '0, 1);
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    step(0, a, '0, 0);
    v = reg_rdata;
  endtask

  initial begin
    #(CLK * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #(CLK/2);
    rst_n = 1;
    #1;
    chk("R1 count", count_o, 0);
    chk("R1 irq", W'(irq), 0);
    chk("R1 tout", W'(tout), 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 flag", v, 0);
    rd(2'd1, v); chk("R1 cmp", v, 0);

    wr_reg(2'd1, 3);
    wr_reg(2'd0, 4'b0111);
    ticks(3); chk("R3 count after 3", count_o, 3);
    step(0, 2'd3, '0, 0); chk("R3 hold without tick", count_o, 3);
    ticks(1); chk("R4 wrap", count_o, 0); chk("R8 irq raised", W'(irq), 1);
    wr_reg(2'd2, 0); chk("R9 write 0 no clear", W'(irq), 1);
    wr_reg(2'd2, 1); chk("R9 w1c", W'(irq), 0);
    ticks(3);
    step(1, 2'd2, 1, 1); chk("R9 set wins", W'(irq), 1);
    wr_reg(2'd2, 1);
    ticks(2);
    wr_reg(2'd0, 4'b0110); chk("R10 disable resets", count_o, 0);
    ticks(2); chk("R10 stays stopped", count_o, 0);

    wr_reg(2'd0, 4'b0011);
    ticks(4);
    rd(2'd0, v); chk("R5 one-shot clears enable", v & 1, 0);
    ticks(2); chk("R5 stays at 0", count_o, 0);

    wr_reg(2'd2, 1);
    wr_reg(2'd0, 4'b1011);
    ticks(4); chk("R7 toggle high", W'(tout), 1);
    ticks(4); chk("R7 toggle low", W'(tout), 0);
    ticks(4);
    wr_reg(2'd0, 4'b1010);
    ticks(3); chk("R7 hold when disabled", W'(tout), 1);

    wr_reg(2'd0, 4'b1111);
    ticks(4);
    rd(2'd0, v); chk("R6 mode 11 keeps enable", v & 1, 1);

    wr_reg(2'd1, 0);
    wr_reg(2'd0, 4'b0110);
    wr_reg(2'd2, 1);
    wr_reg(2'd0, 4'b0111);
    ticks(1); chk("R4 zero compare step", count_o, 1);
    ticks(1); chk("R4 zero compare wrap", count_o, 0); chk("R4 zero compare irq", W'(irq), 1);

    wr_reg(2'd1, 1);
    wr_reg(2'd0, 4'b0010);
    wr_reg(2'd0, 4'b0011);
    ticks(1);
    step(1, 2'd0, 4'b0011, 1);
    rd(2'd0, v); chk("R10 write beats one-shot stop", v & 1, 1);

    wr_reg(2'd0, 4'b0000);
    wr_reg(2'd2, 1);
    wr_reg(2'd0, 4'b0101);
    ticks(4);
    rd(2'd2, v); chk("R8 no flag without ie", v, 0);

    for (int n = 0; n < 6000; n++) begin
      int r = $urandom % 100;
      logic tk = ($urandom % 4) != 0;
      if (r < 6)
        step(1, 2'd0, W'($urandom % 16), tk);
      else if (r < 10)
        step(1, 2'd1, (($urandom % 8) == 0) ? W'($urandom) : W'($urandom % 16), tk);
      else if (r < 16)
        step(1, 2'd2, W'($urandom % 2), tk);
      else if (r < 18)
        step(1, 2'd3, W'($urandom), tk);
      else
        step(0, 2'($urandom), '0, tk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule